// File: doc/BRIEF.md
# Serial Frame Aligner with Lock Detection

This block sits behind a clock and data recovery front end. It takes a serial stream that has already been sampled, one bit on each bit-clock cycle. Each frame is 28 bits long. It carries 24 payload bits and four overhead bits: a pair of embedded clock bits that always read 1 and 0, a balance flag that marks whether the payload went out inverted, and an integrity bit that gives even parity. The aligner needs no reference clock and no special training pattern. It finds the frame boundary from ordinary payload traffic by testing candidate boundaries against the fixed clock bits and the parity rule.

In the hunt phase every bit position is tried in turn, so a mismatch slides the candidate boundary by one bit. A match starts a verify phase that must see eight consecutive good frames on the same boundary. On the eighth good frame the block raises its lock flag and its output enable. In that same cycle it strobes the first recovered word, with any inversion already removed. Once locked, each good frame yields one word and a one-cycle strobe. Up to three bad frames in a row are tolerated. A fourth bad frame in a row drops lock, clears the outputs and restarts the hunt. The time to acquire lock depends on the data, because a chance match on misaligned payload can cost a frame before the hunt resumes. `VERIFY_N` must be at least 2.

Top module: `frame_aligner`

## Requirements
- R1: `ser_bit_i` is sampled on every rising clock edge. A frame is 28 bits in arrival order: bit 0 is a clock bit equal to 1, bits 1..24 are the payload least significant bit first, bit 25 is the balance flag, bit 26 is the integrity bit, and bit 27 is a clock bit equal to 0.
- R2: A candidate frame counts as good only when bit 0 is 1, bit 27 is 0, and bits 1..26 hold an even number of ones. Frames that break the clock bits or the parity produce no word.
- R3: Lock is reached on arbitrary payload with no sync pattern. The first word delivered is from the eighth consecutive good frame on one boundary, so it can be from no earlier frame than the eighth after the stream starts.
- R4: After reset, `lock_o`, `out_en_o` and `frame_valid_o` are 0 and `data_o` is all zeros.
- R5: While `out_en_o` is 0, `data_o` is zero and `frame_valid_o` is 0. `out_en_o` follows `lock_o`.
- R6: `lock_o` rises in the same cycle as the first `frame_valid_o` pulse of a lock period.
- R7: When the balance flag is 1, `data_o` carries the 24 sent bits inverted back, so it equals the original payload.
- R8: While locked, each good frame produces exactly one single-cycle `frame_valid_o` pulse, and the words come out in stream order. Strobes are at least 28 cycles apart.
- R9: While locked, a bad frame produces no strobe and leaves `data_o` unchanged. Fewer than four bad frames in a row keep lock.
- R10: Four consecutive bad frames while locked drop `lock_o` and `out_en_o` and clear `data_o`. The aligner then hunts again and can lock anew.
- R11: A bad frame during verification restarts the search, so the good frames before it do not count toward the eight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bit clock |
| rst_i | input | 1 | Synchronous active-high reset |
| ser_bit_i | input | 1 | Retimed serial data, one bit per cycle |
| data_o | output | 24 | Recovered payload word, zero while disabled |
| frame_valid_o | output | 1 | One-cycle strobe per recovered word |
| lock_o | output | 1 | Frame lock indicator |
| out_en_o | output | 1 | Parallel output enable |

## Verification
The bench begins the stream on a misaligned bit offset and mixes inverted and plain payloads. It then checks that the first word matches the eighth aligned frame. An aligner that released data on its first candidate would show an earlier word. One that skipped the inversion step would return complemented payloads. While locked, the bench injects runs of clock-bit and parity faults that stop short of the loss limit, and then a run that reaches it. A wrong loss counter would either drop lock early, which shows as a missing word and a lock fall, or never drop it. A parity fault placed inside verification shows whether the good-frame count really restarts. A design that kept the count would lock on a word from before the eighth frame after the fault.

// File: rtl/fa_pkg.sv
package fa_pkg;
  // Alignment search states
  typedef enum logic [1:0] {
    ST_HUNT   = 2'd0,
    ST_VERIFY = 2'd1,
    ST_LOCKED = 2'd2
  } align_st_e;
endpackage

// File: rtl/fa_window.sv
// Sliding window over the most recent FRAME_W received bits.
// The oldest bit sits at index 0, the newest at index FRAME_W-1.
module fa_window #(
  parameter int FRAME_W = 28
) (
  input  logic               clk_i,
  input  logic               rst_i,
  input  logic               bit_i,
  output logic [FRAME_W-1:0] win_o
);
  always_ff @(posedge clk_i) begin
    if (rst_i) win_o <= '0;
    else       win_o <= {bit_i, win_o[FRAME_W-1:1]};
  end
endmodule

// File: rtl/fa_frame_check.sv
// Tests a window as a frame candidate and decodes its payload.
module fa_frame_check #(
  parameter int PAY_W = 24
) (
  input  logic [PAY_W+3:0] win_i,
  output logic             good_o,
  output logic [PAY_W-1:0] word_o
);
  localparam int FRAME_W = PAY_W + 4;
  localparam int BAL_POS = PAY_W + 1;

  logic lead_one, tail_zero, parity_even, invert;

  always_comb begin
    lead_one    = win_i[0];
    tail_zero   = ~win_i[FRAME_W-1];
    parity_even = ~(^win_i[FRAME_W-2:1]);
    invert      = win_i[BAL_POS];
    good_o      = lead_one & tail_zero & parity_even;
    word_o      = win_i[PAY_W:1] ^ {PAY_W{invert}};
  end
endmodule

// File: rtl/fa_align_fsm.sv
// Boundary search: hunt bit by bit, verify a run of good frames,
// then track frames and count consecutive misses.
module fa_align_fsm
  import fa_pkg::*;
#(
  parameter int FRAME_W  = 28,
  parameter int VERIFY_N = 8,
  parameter int LOSS_N   = 4
) (
  input  logic clk_i,
  input  logic rst_i,
  input  logic good_i,
  output logic emit_o,
  output logic lock_set_o,
  output logic lock_clr_o
);
  localparam int PW = $clog2(FRAME_W);
  localparam int VW = $clog2(VERIFY_N + 1);
  localparam int LW = $clog2(LOSS_N + 1);
  localparam logic [PW-1:0] POS_LAST  = PW'(FRAME_W - 1);
  localparam logic [VW-1:0] GOOD_LAST = VW'(VERIFY_N - 1);
  localparam logic [LW-1:0] MISS_LAST = LW'(LOSS_N - 1);

  align_st_e     state;
  logic [PW-1:0] pos;
  logic [VW-1:0] good_cnt;
  logic [LW-1:0] miss_cnt;
  logic          frame_end;

  assign frame_end = (pos == POS_LAST);

  always_comb begin
    emit_o     = 1'b0;
    lock_set_o = 1'b0;
    lock_clr_o = 1'b0;
    case (state)
      ST_VERIFY: begin
        if (frame_end && good_i && good_cnt == GOOD_LAST) begin
          emit_o     = 1'b1;
          lock_set_o = 1'b1;
        end
      end
      ST_LOCKED: begin
        if (frame_end && good_i) emit_o = 1'b1;
        if (frame_end && !good_i && miss_cnt == MISS_LAST) lock_clr_o = 1'b1;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      state    <= ST_HUNT;
      pos      <= '0;
      good_cnt <= '0;
      miss_cnt <= '0;
    end else begin
      pos <= frame_end ? '0 : pos + 1'b1;
      case (state)
        ST_HUNT: begin
          // every bit position is a candidate; a miss slides by one bit
          if (good_i) begin
            state    <= ST_VERIFY;
            pos      <= '0;
            good_cnt <= VW'(1);
          end
        end
        ST_VERIFY: begin
          if (frame_end) begin
            if (!good_i) begin
              state <= ST_HUNT;
            end else if (good_cnt == GOOD_LAST) begin
              state    <= ST_LOCKED;
              miss_cnt <= '0;
            end else begin
              good_cnt <= good_cnt + 1'b1;
            end
          end
        end
        ST_LOCKED: begin
          if (frame_end) begin
            if (good_i) begin
              miss_cnt <= '0;
            end else if (miss_cnt == MISS_LAST) begin
              state <= ST_HUNT;
            end else begin
              miss_cnt <= miss_cnt + 1'b1;
            end
          end
        end
        default: state <= ST_HUNT;
      endcase
    end
  end
endmodule

// File: rtl/frame_aligner.sv
// Top: window, candidate test, search control and registered outputs.
module frame_aligner #(
  parameter int PAY_W    = 24,
  parameter int VERIFY_N = 8,
  parameter int LOSS_N   = 4
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic             ser_bit_i,
  output logic [PAY_W-1:0] data_o,
  output logic             frame_valid_o,
  output logic             lock_o,
  output logic             out_en_o
);
  localparam int FRAME_W = PAY_W + 4;

  logic [FRAME_W-1:0] win;
  logic               good;
  logic [PAY_W-1:0]   word;
  logic               emit, lock_set, lock_clr;

  fa_window #(.FRAME_W(FRAME_W)) u_win (
    .clk_i (clk_i),
    .rst_i (rst_i),
    .bit_i (ser_bit_i),
    .win_o (win)
  );

  fa_frame_check #(.PAY_W(PAY_W)) u_chk_frame (
    .win_i  (win),
    .good_o (good),
    .word_o (word)
  );

  fa_align_fsm #(
    .FRAME_W  (FRAME_W),
    .VERIFY_N (VERIFY_N),
    .LOSS_N   (LOSS_N)
  ) u_fsm (
    .clk_i      (clk_i),
    .rst_i      (rst_i),
    .good_i     (good),
    .emit_o     (emit),
    .lock_set_o (lock_set),
    .lock_clr_o (lock_clr)
  );

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      data_o        <= '0;
      frame_valid_o <= 1'b0;
      lock_o        <= 1'b0;
      out_en_o      <= 1'b0;
    end else begin
      frame_valid_o <= emit;
      if (emit) data_o <= word;
      if (lock_set) begin
        lock_o   <= 1'b1;
        out_en_o <= 1'b1;
      end
      if (lock_clr) begin
        lock_o   <= 1'b0;
        out_en_o <= 1'b0;
        data_o   <= '0;
      end
    end
  end
endmodule

// File: rtl/fa_checker.sv
module fa_checker #(
  parameter int PAY_W   = 24,
  parameter int FRAME_W = 28
) (
  input logic             clk_i,
  input logic             rst_i,
  input logic [PAY_W-1:0] data_i,
  input logic             fv_i,
  input logic             lock_i,
  input logic             oe_i
);
  localparam int GW = $clog2(FRAME_W + 1);
  localparam logic [GW-1:0] GAP_MAX = GW'(FRAME_W);
  localparam logic [GW-1:0] GAP_MIN = GW'(FRAME_W - 1);

  logic [GW-1:0] gap;
  logic          seen;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      gap  <= '0;
      seen <= 1'b0;
    end else if (fv_i) begin
      gap  <= '0;
      seen <= 1'b1;
    end else if (gap != GAP_MAX) begin
      gap <= gap + 1'b1;
    end
  end

  p_quiet_off_r5: assert property (@(posedge clk_i) disable iff (rst_i)
    !oe_i |-> (data_i == '0 && !fv_i));
  p_lock_with_word_r6: assert property (@(posedge clk_i) disable iff (rst_i)
    $rose(lock_i) |-> fv_i);
  p_strobe_locked_r8: assert property (@(posedge clk_i) disable iff (rst_i)
    fv_i |-> (lock_i && oe_i));
  p_strobe_single_r8: assert property (@(posedge clk_i) disable iff (rst_i)
    fv_i |=> !fv_i);
  p_strobe_spacing_r8: assert property (@(posedge clk_i) disable iff (rst_i)
    (fv_i && seen) |-> gap >= GAP_MIN);
  p_hold_between_r9: assert property (@(posedge clk_i) disable iff (rst_i)
    (lock_i && !fv_i) |-> $stable(data_i));
  p_drop_disables_r10: assert property (@(posedge clk_i) disable iff (rst_i)
    $fell(lock_i) |-> (!oe_i && data_i == '0));
endmodule

bind frame_aligner fa_checker #(.PAY_W(PAY_W), .FRAME_W(FRAME_W)) i_fa_checker (
  .clk_i  (clk_i),
  .rst_i  (rst_i),
  .data_i (data_o),
  .fv_i   (frame_valid_o),
  .lock_i (lock_o),
  .oe_i   (out_en_o)
);

// File: tb/test_frame_aligner.sv
`timescale 1ns/1ps
module test_frame_aligner;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ser = 1'b0;
  logic [23:0] data;
  logic        fv, lock, oe;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  frame_aligner i_frame_aligner (
    .clk_i         (clk),
    .rst_i         (rst),
    .ser_bit_i     (ser),
    .data_o        (data),
    .frame_valid_o (fv),
    .lock_o        (lock),
    .out_en_o      (oe)
  );

  // {balance flag, payload}: payloads distinct, expected word = payload (R7)
  localparam logic [24:0] VEC [16] = '{
    {1'b0, 24'hA5C31E}, {1'b1, 24'h0F0F0F}, {1'b0, 24'h123456}, {1'b1, 24'hFEDCBA},
    {1'b0, 24'h00FF00}, {1'b0, 24'h5A5A5A}, {1'b1, 24'h800001}, {1'b0, 24'h3C3C3C},
    {1'b1, 24'h777777}, {1'b0, 24'h9ABCDE}, {1'b1, 24'h010101}, {1'b0, 24'hCAFE42},
    {1'b0, 24'hBEEF01}, {1'b1, 24'h246813}, {1'b0, 24'hF00F0F}, {1'b1, 24'h6B6B6B}
  };

  // monitor state
  logic [23:0] rx [256];
  int  rx_n = 0;
  int  drop_at = -1;
  int  drops = 0;
  bit  prev_lock = 1'b0;
  bit  bad_fv = 1'b0, bad_rise = 1'b0, bad_quiet = 1'b0;

  always @(negedge clk) begin
    if (!rst) begin
      if (fv) begin
        if (rx_n < 256) rx[rx_n] = data;
        rx_n++;
        if (!(lock && oe)) bad_fv = 1'b1;
      end
      if (lock && !prev_lock && !fv) bad_rise = 1'b1;
      if (!oe && (data != 24'd0 || fv)) bad_quiet = 1'b1;
      if (prev_lock && !lock) begin
        drops++;
        if (drop_at < 0) drop_at = rx_n;
      end
      prev_lock = lock;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // kind 0 good, 1 broken leading clock bit, 2 broken parity (R1, R2)
  function automatic logic [27:0] mk_frame(input logic [23:0] pay, input bit inv, input int kind);
    logic [27:0] f;
    f[0]     = 1'b1;
    f[24:1]  = inv ? ~pay : pay;
    f[25]    = inv;
    f[26]    = ^f[25:1];
    f[27]    = 1'b0;
    if (kind == 1) f[0] = 1'b0;
    if (kind == 2) f[26] = ~f[26];
    return f;
  endfunction

  task automatic send(input logic [23:0] pay, input bit inv, input int kind);
    logic [27:0] f;
    f = mk_frame(pay, inv, kind);
    for (int i = 0; i < 28; i++) begin
      @(negedge clk);
      ser = f[i];
    end
  endtask

  function automatic logic [23:0] e_pay(input int t);
    return 24'h400000 + 24'(t) * 24'h010203;
  endfunction

  initial begin
    int k, base, j;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    // R4 reset state
    chk(lock == 1'b0, "R4 lock", 32'(lock), 0);
    chk(oe == 1'b0,   "R4 out_en", 32'(oe), 0);
    chk(fv == 1'b0,   "R4 strobe", 32'(fv), 0);
    chk(data == 24'd0, "R4 data", 32'(data), 0);

    // misaligned start, then the vector table (R1, R3, R7, R8)
    ser = 1'b1; @(negedge clk);
    ser = 1'b1; @(negedge clk);
    ser = 1'b0;
    for (int v = 0; v < 16; v++) send(VEC[v][23:0], VEC[v][24], 0);

    // locked: 3 bad frames are tolerated (R9, R2)
    send(24'h111111, 1'b0, 0);
    send(24'hDEAD00, 1'b0, 1);
    send(24'hDEAD01, 1'b1, 1);
    send(24'hDEAD02, 1'b0, 2);
    send(24'h222222, 1'b1, 0);
    send(24'h333333, 1'b0, 0);
    chk(drops == 0, "R9 lock kept through 3 bad frames", 32'(drops), 0);

    // 4 bad frames drop lock (R10)
    for (int b = 0; b < 4; b++) send(24'h0BAD00 + 24'(b), 1'b0, (b % 2) + 1);
    send(24'h500000, 1'b0, 0);
    chk(drops == 1, "R10 one lock drop", 32'(drops), 1);
    chk(lock == 1'b0, "R10 lock low", 32'(lock), 0);
    chk(oe == 1'b0, "R10 out_en low", 32'(oe), 0);
    chk(data == 24'd0, "R10 data cleared", 32'(data), 0);

    // verification interrupted by a parity fault (R11)
    for (int d = 1; d < 5; d++) send(24'h500000 + 24'(d), 1'b0, 0);
    send(24'h5FFFFF, 1'b0, 2);
    for (int t = 0; t < 11; t++) send(e_pay(t), t[0], 0);
    ser = 1'b0;
    repeat (30) @(negedge clk);

    // table words
    k = -1;
    for (int t = 0; t < 16; t++) if (rx[0] == VEC[t][23:0]) k = t;
    chk(k >= 7 && k <= 10, "R3 first word is from 8th aligned frame or later", 32'(k), 7);
    if (k >= 0) begin
      for (int i = 0; i + k < 16; i++)
        chk(rx[i] == VEC[k+i][23:0], VEC[k+i][24] ? "R7 inverted word" : "R8 word order",
            32'(rx[i]), 32'(VEC[k+i][23:0]));
      base = 16 - k;
      chk(rx[base] == 24'h111111, "R8 word after table", 32'(rx[base]), 32'h111111);
      chk(rx[base+1] == 24'h222222, "R9 bad frames skipped, inverted next", 32'(rx[base+1]), 32'h222222);
      chk(rx[base+2] == 24'h333333, "R9 following word", 32'(rx[base+2]), 32'h333333);
      chk(drop_at == base + 3, "R10 no word during loss run", 32'(drop_at), 32'(base + 3));
    end

    // relock words
    j = -1;
    if (drop_at >= 0) for (int t = 0; t < 11; t++) if (rx[drop_at] == e_pay(t)) j = t;
    chk(j >= 7 && j <= 9, "R11 relock needs 8 good after fault", 32'(j), 7);
    if (j >= 0)
      for (int i = 0; i + j < 11; i++)
        chk(rx[drop_at+i] == e_pay(j+i), "R10 words after relock", 32'(rx[drop_at+i]), 32'(e_pay(j+i)));

    chk(!bad_fv, "R8 strobe only when locked", 32'(bad_fv), 0);
    chk(!bad_rise, "R6 lock rises with first strobe", 32'(bad_rise), 0);
    chk(!bad_quiet, "R5 quiet outputs when disabled", 32'(bad_quiet), 0);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule